// File: doc/BRIEF.md
# Paged Call Address Generator

This block produces the program counter of a small controller whose program memory is cut into pages of 2K words. A jump or subroutine call carries only the low address bits inside its opcode. The remaining upper bits come from a page register that software loads ahead of time with an ordinary register write. A subroutine call pushes the complete return address onto a hardware stack. A return pops that stack and reloads every bit of the program counter, so the caller's page comes back whatever the page register holds at that moment.

Interrupt entry jumps to a fixed vector and pushes the address of the interrupted instruction. It leaves the page register alone, so the interrupted code still sees its own page selection when the handler returns. Instruction decode, program memory and interrupt arbitration sit outside the block. They drive its one-cycle strobes and read back the next program counter and the stack status.

Top module: `paged_pc_gen`

## Requirements
- R1: After reset the program counter is 0, the stack is empty (depth 0, empty_o 1, full_o 0), ovf_o and unf_o are 0, and page_o is 0.
- R2: A jump loads pc_o with {page, tgt_i}. The page is bits [4:3] of the page register, and bit 3 is the low page bit. With page register value 08h, target 123h yields 923h.
- R3: A call loads the same target as a jump. It also pushes pc_o+1, all 13 bits, and raises depth_o by one.
- R4: A return loads pc_o with the most recently pushed 13-bit value and lowers depth_o by one. The upper bits come from the stack, not from the current page register.
- R5: A page register write changes no program counter value until the next jump or call. A call or jump in the same cycle as the write still uses the old page. A sequential step in the write cycle advances by exactly one.
- R6: A sequential step adds one to the full 13-bit counter and wraps from 1FFFh to 0000h.
- R7: The stack is 8 entries deep and circular. A push while full overwrites the oldest entry, keeps depth_o at 8 and raises ovf_o for exactly the following cycle.
- R8: A return with an empty stack raises unf_o for one cycle, leaves depth_o at 0 and advances pc_o by one.
- R9: Interrupt entry loads pc_o with the vector 0004h and pushes the current, unincremented pc_o. It leaves the page register unchanged.
- R10: When strobes coincide, the winner follows the order interrupt, return, call, jump, step. Only the winner takes effect.
- R11: Built with one used page bit, the block ignores page register bit 4 and the top address bit of every jump or call target is 0.
- R12: depth_o never exceeds the stack depth, and empty_o and full_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Advance to the next sequential address |
| jump_i | input | 1 | Jump to paged target |
| call_i | input | 1 | Call paged target, push return address |
| ret_i | input | 1 | Return to popped address |
| irq_i | input | 1 | Interrupt entry to the vector |
| tgt_i | input | 11 | Low target bits from the opcode |
| lat_we_i | input | 1 | Page register write enable |
| lat_wd_i | input | 8 | Page register write data |
| pc_o | output | 13 | Program counter |
| page_o | output | 2 | Effective page bits held in the page register |
| depth_o | output | 4 | Number of stacked return addresses |
| empty_o | output | 1 | Stack holds no entry |
| full_o | output | 1 | Stack holds the maximum number of entries |
| ovf_o | output | 1 | One-cycle pulse after a push onto a full stack |
| unf_o | output | 1 | One-cycle pulse after a return on an empty stack |

## Verification
The bench builds the block twice. One instance uses the default values (13-bit counter, 11-bit opcode field, two used page bits, eight-entry stack). The second instance is identical except that it uses a single page bit. The default instance is small enough for the counter wrap at 1FFFh and the overwrite of the oldest stack entry to be reached within a few dozen cycles. The single-bit instance shares the same stimulus, which shows directly that the same page register value gives a different upper target bit when bit 4 is configured away.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

   // Winning action for one cycle, decided by fixed priority
   typedef enum logic [2:0] {
      PC_HOLD = 3'd0,
      PC_STEP = 3'd1,
      PC_JUMP = 3'd2,
      PC_CALL = 3'd3,
      PC_RET  = 3'd4,
      PC_IRQ  = 3'd5
   } pc_op_e;

endpackage

// File: rtl/pcg_op_sel.sv
module pcg_op_sel
   import pcg_pkg::*;
(
   input  logic   step_i,
   input  logic   jump_i,
   input  logic   call_i,
   input  logic   ret_i,
   input  logic   irq_i,
   output pc_op_e op_o
);

   always_comb begin
      if (irq_i)       op_o = PC_IRQ;
      else if (ret_i)  op_o = PC_RET;
      else if (call_i) op_o = PC_CALL;
      else if (jump_i) op_o = PC_JUMP;
      else if (step_i) op_o = PC_STEP;
      else             op_o = PC_HOLD;
   end

endmodule

// File: rtl/pcg_page_latch.sv
module pcg_page_latch #(
   parameter int LATCH_W   = 8,
   parameter int PAGE_LSB  = 3,
   parameter int PAGE_BITS = 2,
   parameter int USED_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_i,
   input  logic [LATCH_W-1:0]   wd_i,
   output logic [PAGE_BITS-1:0] page_o
);

   if (PAGE_LSB + PAGE_BITS > LATCH_W) begin : g_bad_field
      $error("page field does not fit in the page register");
   end
   if (USED_BITS > PAGE_BITS || USED_BITS < 0) begin : g_bad_used
      $error("used page bits out of range");
   end

   logic [PAGE_BITS-1:0] field_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field_q <= '0;
      end else if (we_i) begin
         field_q <= wd_i[PAGE_LSB +: PAGE_BITS];
      end
   end

   // Bits above the configured count are tied low
   for (genvar b = 0; b < PAGE_BITS; b++) begin : g_bit
      if (b < USED_BITS) begin : g_used
         assign page_o[b] = field_q[b];
      end else begin : g_unused
         assign page_o[b] = 1'b0;
      end
   end

endmodule

// File: rtl/pcg_ret_stack.sv
module pcg_ret_stack #(
   parameter int W     = 13,
   parameter int DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push_i,
   input  logic                         pop_i,
   input  logic [W-1:0]                 din_i,
   output logic [W-1:0]                 top_o,
   output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
   output logic                         empty_o,
   output logic                         full_o,
   output logic                         ovf_o,
   output logic                         unf_o
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST    = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("stack depth must be at least 2");
   end

   logic [W-1:0]     slot_q [DEPTH];
   logic [PTR_W-1:0] wptr_q;
   logic [PTR_W-1:0] wptr_nx;
   logic [PTR_W-1:0] wptr_pv;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             unf_q;
   logic             is_empty;
   logic             is_full;

   // Pointer arithmetic: free wrap for powers of two, compare otherwise
   if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wptr_nx = wptr_q + 1'b1;
      assign wptr_pv = wptr_q - 1'b1;
   end else begin : g_mod
      assign wptr_nx = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      assign wptr_pv = (wptr_q == '0) ? LAST : wptr_q - 1'b1;
   end

   assign is_empty = (cnt_q == '0);
   assign is_full  = (cnt_q == CNT_MAX);

   always_ff @(posedge clk) begin
      if (push_i) begin
         slot_q[wptr_q] <= din_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         cnt_q  <= '0;
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
      end else begin
         ovf_q <= push_i && is_full;
         unf_q <= pop_i && !push_i && is_empty;
         if (push_i) begin
            wptr_q <= wptr_nx;
            if (!is_full) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (pop_i && !is_empty) begin
            wptr_q <= wptr_pv;
            cnt_q  <= cnt_q - 1'b1;
         end
      end
   end

   assign top_o   = slot_q[wptr_pv];
   assign cnt_o   = cnt_q;
   assign empty_o = is_empty;
   assign full_o  = is_full;
   assign ovf_o   = ovf_q;
   assign unf_o   = unf_q;

endmodule

// File: rtl/paged_pc_gen.sv
module paged_pc_gen
   import pcg_pkg::*;
#(
   parameter int PC_W           = 13,
   parameter int OPC_W          = 11,
   parameter int LATCH_W        = 8,
   parameter int PAGE_LSB       = 3,
   parameter int USED_PAGE_BITS = 2,
   parameter int STK_DEPTH      = 8,
   parameter int IRQ_VEC        = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              step_i,
   input  logic                              jump_i,
   input  logic                              call_i,
   input  logic                              ret_i,
   input  logic                              irq_i,
   input  logic [OPC_W-1:0]                  tgt_i,
   input  logic                              lat_we_i,
   input  logic [LATCH_W-1:0]                lat_wd_i,
   output logic [PC_W-1:0]                   pc_o,
   output logic [PC_W-OPC_W-1:0]             page_o,
   output logic [$clog2(STK_DEPTH+1)-1:0]    depth_o,
   output logic                              empty_o,
   output logic                              full_o,
   output logic                              ovf_o,
   output logic                              unf_o
);

   localparam int PAGE_BITS = PC_W - OPC_W;
   localparam logic [PC_W-1:0] VEC = PC_W'(IRQ_VEC);

   if (PC_W <= OPC_W) begin : g_bad_width
      $error("counter must be wider than the opcode field");
   end
   if (IRQ_VEC < 0 || IRQ_VEC >= (1 << PC_W)) begin : g_bad_vec
      $error("interrupt vector outside program space");
   end

   pc_op_e               op;
   logic [PAGE_BITS-1:0] page;
   logic [PC_W-1:0]      pc_q;
   logic [PC_W-1:0]      pc_nx;
   logic [PC_W-1:0]      pc_inc;
   logic [PC_W-1:0]      tgt_full;
   logic [PC_W-1:0]      push_val;
   logic [PC_W-1:0]      stk_top;
   logic                 push;
   logic                 pop;
   logic                 stk_empty;

   pcg_op_sel u_sel (
      .step_i (step_i),
      .jump_i (jump_i),
      .call_i (call_i),
      .ret_i  (ret_i),
      .irq_i  (irq_i),
      .op_o   (op)
   );

   pcg_page_latch #(
      .LATCH_W   (LATCH_W),
      .PAGE_LSB  (PAGE_LSB),
      .PAGE_BITS (PAGE_BITS),
      .USED_BITS (USED_PAGE_BITS)
   ) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (lat_we_i),
      .wd_i   (lat_wd_i),
      .page_o (page)
   );

   assign pc_inc   = pc_q + 1'b1;
   assign tgt_full = {page, tgt_i};
   assign push     = (op == PC_CALL) || (op == PC_IRQ);
   assign pop      = (op == PC_RET);
   assign push_val = (op == PC_IRQ) ? pc_q : pc_inc;

   pcg_ret_stack #(
      .W     (PC_W),
      .DEPTH (STK_DEPTH)
   ) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .pop_i   (pop),
      .din_i   (push_val),
      .top_o   (stk_top),
      .cnt_o   (depth_o),
      .empty_o (stk_empty),
      .full_o  (full_o),
      .ovf_o   (ovf_o),
      .unf_o   (unf_o)
   );

   always_comb begin
      unique case (op)
         PC_IRQ:  pc_nx = VEC;
         PC_RET:  pc_nx = stk_empty ? pc_inc : stk_top;
         PC_CALL: pc_nx = tgt_full;
         PC_JUMP: pc_nx = tgt_full;
         PC_STEP: pc_nx = pc_inc;
         default: pc_nx = pc_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else begin
         pc_q <= pc_nx;
      end
   end

   assign pc_o    = pc_q;
   assign page_o  = page;
   assign empty_o = stk_empty;

endmodule

// File: rtl/paged_pc_gen_chk.sv
module paged_pc_gen_chk #(
   parameter int PC_W      = 13,
   parameter int OPC_W     = 11,
   parameter int STK_DEPTH = 8,
   parameter int IRQ_VEC   = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            step_i,
   input logic                            jump_i,
   input logic                            call_i,
   input logic                            ret_i,
   input logic                            irq_i,
   input logic [OPC_W-1:0]                tgt_i,
   input logic                            lat_we_i,
   input logic [PC_W-1:0]                 pc_o,
   input logic [PC_W-OPC_W-1:0]           page_o,
   input logic [$clog2(STK_DEPTH+1)-1:0]  depth_o,
   input logic                            empty_o,
   input logic                            full_o,
   input logic                            ovf_o,
   input logic                            unf_o
);

   localparam int CNT_W = $clog2(STK_DEPTH + 1);

   logic only_step;
   logic only_jump;
   logic call_wins;
   assign only_step = step_i && !jump_i && !call_i && !ret_i && !irq_i;
   assign only_jump = jump_i && !call_i && !ret_i && !irq_i;
   assign call_wins = call_i && !ret_i && !irq_i;

   // R6
   step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      only_step |=> pc_o == PC_W'($past(pc_o) + 1'b1));

   // R2
   jump_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      only_jump |=> pc_o[OPC_W-1:0] == $past(tgt_i));

   // R3
   call_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_wins && !full_o) |=> depth_o == CNT_W'($past(depth_o) + 1'b1));

   // R9
   irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_i && !lat_we_i) |=> (pc_o == PC_W'(IRQ_VEC)) && $stable(page_o));

   // R7
   ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> full_o && $past(full_o));

   // R8
   unf_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |-> empty_o && $past(empty_o));

   // R12
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_o <= CNT_W'(STK_DEPTH)) && !(empty_o && full_o));

endmodule

bind paged_pc_gen paged_pc_gen_chk #(
   .PC_W      (PC_W),
   .OPC_W     (OPC_W),
   .STK_DEPTH (STK_DEPTH),
   .IRQ_VEC   (IRQ_VEC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .step_i   (step_i),
   .jump_i   (jump_i),
   .call_i   (call_i),
   .ret_i    (ret_i),
   .irq_i    (irq_i),
   .tgt_i    (tgt_i),
   .lat_we_i (lat_we_i),
   .pc_o     (pc_o),
   .page_o   (page_o),
   .depth_o  (depth_o),
   .empty_o  (empty_o),
   .full_o   (full_o),
   .ovf_o    (ovf_o),
   .unf_o    (unf_o)
);

// File: tb/paged_pc_gen_tb.sv
module paged_pc_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 1'b0, jump_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, irq_i = 1'b0;
   logic [10:0] tgt_i = '0;
   logic        lat_we_i = 1'b0;
   logic [7:0]  lat_wd_i = '0;
   logic [12:0] pc_o, pc_n;
   logic [1:0]  page_o, page_n;
   logic [3:0]  depth_o, depth_n;
   logic        empty_o, full_o, ovf_o, unf_o;
   logic        empty_n, full_n, ovf_n, unf_n;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   paged_pc_gen u_dut (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i),
      .call_i(call_i), .ret_i(ret_i), .irq_i(irq_i), .tgt_i(tgt_i),
      .lat_we_i(lat_we_i), .lat_wd_i(lat_wd_i), .pc_o(pc_o), .page_o(page_o),
      .depth_o(depth_o), .empty_o(empty_o), .full_o(full_o),
      .ovf_o(ovf_o), .unf_o(unf_o)
   );

   paged_pc_gen #(.USED_PAGE_BITS(1)) u_dut_nar (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i),
      .call_i(call_i), .ret_i(ret_i), .irq_i(irq_i), .tgt_i(tgt_i),
      .lat_we_i(lat_we_i), .lat_wd_i(lat_wd_i), .pc_o(pc_n), .page_o(page_n),
      .depth_o(depth_n), .empty_o(empty_n), .full_o(full_n),
      .ovf_o(ovf_n), .unf_o(unf_n)
   );

   // Row: op[39:37] tgt[36:26] we[25] wd[24:17] exp_pc[16:4] exp_depth[3:0]
   // op: 0 idle, 1 step, 2 jump, 3 call, 4 return, 5 interrupt
   localparam int NV = 19;
   localparam logic [39:0] VEC [NV] = '{
      {3'd1, 11'h000, 1'b0, 8'h00, 13'h0001, 4'd0},
      {3'd1, 11'h000, 1'b0, 8'h00, 13'h0002, 4'd0},
      {3'd1, 11'h000, 1'b1, 8'h08, 13'h0003, 4'd0},
      {3'd2, 11'h123, 1'b0, 8'h00, 13'h0923, 4'd0},
      {3'd1, 11'h000, 1'b0, 8'h00, 13'h0924, 4'd0},
      {3'd3, 11'h055, 1'b0, 8'h00, 13'h0855, 4'd1},
      {3'd0, 11'h000, 1'b1, 8'h00, 13'h0855, 4'd1},
      {3'd3, 11'h200, 1'b0, 8'h00, 13'h0200, 4'd2},
      {3'd4, 11'h000, 1'b0, 8'h00, 13'h0856, 4'd1},
      {3'd4, 11'h000, 1'b0, 8'h00, 13'h0925, 4'd0},
      {3'd0, 11'h000, 1'b1, 8'h18, 13'h0925, 4'd0},
      {3'd2, 11'h7FF, 1'b0, 8'h00, 13'h1FFF, 4'd0},
      {3'd1, 11'h000, 1'b0, 8'h00, 13'h0000, 4'd0},
      {3'd3, 11'h001, 1'b1, 8'h10, 13'h1801, 4'd1},
      {3'd2, 11'h001, 1'b0, 8'h00, 13'h1001, 4'd1},
      {3'd5, 11'h000, 1'b0, 8'h00, 13'h0004, 4'd2},
      {3'd2, 11'h000, 1'b0, 8'h00, 13'h1000, 4'd2},
      {3'd4, 11'h000, 1'b0, 8'h00, 13'h1001, 4'd1},
      {3'd4, 11'h000, 1'b0, 8'h00, 13'h0001, 4'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge with inputs idle
   task automatic drive(input logic s, j, c, r, i, input logic [10:0] t,
                        input logic we, input logic [7:0] wd);
      step_i = s; jump_i = j; call_i = c; ret_i = r; irq_i = i;
      tgt_i = t; lat_we_i = we; lat_wd_i = wd;
      @(negedge clk);
      step_i = 0; jump_i = 0; call_i = 0; ret_i = 0; irq_i = 0;
      lat_we_i = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 pc", pc_o, 0);
      chk("R1 depth", depth_o, 0);
      chk("R1 empty/full", {empty_o, full_o}, 2'b10);
      chk("R1 ovf/unf", {ovf_o, unf_o}, 2'b00);
      chk("R1 page", page_o, 0);

      // Table walk: R2 R3 R4 R5 R6 R9 sequences
      for (int k = 0; k < NV; k++) begin
         logic [2:0] o;
         o = VEC[k][39:37];
         drive(o == 3'd1, o == 3'd2, o == 3'd3, o == 3'd4, o == 3'd5,
               VEC[k][36:26], VEC[k][25], VEC[k][24:17]);
         chk($sformatf("R2-R6/R9 row %0d pc", k), pc_o, VEC[k][16:4]);
         chk($sformatf("R3/R4 row %0d depth", k), depth_o, VEC[k][3:0]);
      end

      // R11 narrow build ignores page register bit 4; R2 wide build uses it
      do_reset();
      drive(0, 0, 0, 0, 0, 11'h0, 1, 8'h18);
      drive(0, 1, 0, 0, 0, 11'h7FF, 0, 8'h0);
      chk("R2 wide pc", pc_o, 13'h1FFF);
      chk("R11 narrow pc", pc_n, 13'h0FFF);
      chk("R11 narrow page", page_n, 2'b01);
      // R6 wrap at the top
      drive(1, 0, 0, 0, 0, 11'h0, 0, 8'h0);
      chk("R6 wrap", pc_o, 13'h0000);

      // R7 overflow and R8 underflow
      do_reset();
      for (int k = 0; k < 9; k++) begin
         drive(0, 0, 1, 0, 0, 11'(11'h100 + k), 0, 8'h0);
         if (k == 7) begin
            chk("R7 full at 8", {full_o, ovf_o}, 2'b10);
            chk("R7 depth 8", depth_o, 8);
         end
      end
      chk("R7 ovf pulse", ovf_o, 1);
      chk("R7 depth held", depth_o, 8);
      drive(0, 0, 0, 0, 0, 11'h0, 0, 8'h0);
      chk("R7 ovf one cycle", ovf_o, 0);
      for (int k = 8; k >= 1; k--) begin
         drive(0, 0, 0, 1, 0, 11'h0, 0, 8'h0);
         chk("R4 R7 pop order", pc_o, 13'(13'h100 + k));
      end
      chk("R12 empty after pops", {empty_o, depth_o}, 5'b1_0000);
      drive(0, 0, 0, 1, 0, 11'h0, 0, 8'h0);
      chk("R8 unf pulse", unf_o, 1);
      chk("R8 pc advance", pc_o, 13'h0102);
      chk("R8 depth", depth_o, 0);
      drive(0, 0, 0, 0, 0, 11'h0, 0, 8'h0);
      chk("R8 unf one cycle", unf_o, 0);

      // R10 priority
      do_reset();
      drive(1, 1, 1, 1, 1, 11'h300, 0, 8'h0);
      chk("R10 irq wins pc", pc_o, 13'h0004);
      chk("R10 irq wins depth", depth_o, 1);
      drive(0, 0, 1, 1, 0, 11'h300, 0, 8'h0);
      chk("R10 ret over call pc", pc_o, 13'h0000);
      chk("R10 ret over call depth", depth_o, 0);
      drive(1, 1, 1, 0, 0, 11'h050, 0, 8'h0);
      chk("R10 call over jump", {pc_o, depth_o}, {13'h0050, 4'd1});
      drive(1, 1, 0, 0, 0, 11'h060, 0, 8'h0);
      chk("R10 jump over step", {pc_o, depth_o}, {13'h0060, 4'd1});

      // R9 interrupt keeps the page register
      drive(0, 0, 0, 0, 0, 11'h0, 1, 8'h08);
      drive(0, 0, 0, 0, 1, 11'h0, 0, 8'h0);
      chk("R9 vector", pc_o, 13'h0004);
      chk("R9 page kept", page_o, 2'b01);
      drive(0, 0, 0, 1, 0, 11'h0, 0, 8'h0);
      chk("R9 pushed unincremented", pc_o, 13'h0060);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule